// File: doc/BRIEF.md
# Asynchronous Peripheral Byte Loader

This block accepts configuration bytes from a host processor over a plain asynchronous bus and turns them into a serial bit stream for the configuration logic. The host selects the port with a pair of chip selects: one active low, one active high. It writes a byte by pulling the write strobe low while the byte sits on the 8-bit data bus. The block holds that byte in a one-byte buffer and shifts it out, most significant bit first, one bit per configuration clock.

Before it writes the next byte, the host polls the port. It pulls the read strobe low, and the block then drives a status byte onto the bus. The top line carries ready (high) or busy (low), and the other seven lines are driven high. All bus-side controls are asynchronous to the configuration clock, so each one passes through a two-flop synchroniser. The bus drivers are given as a data vector plus an output enable, which the chip pad ring turns into tri-state pins.

Top module: `async_byte_loader`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bus_oe_o` and `ser_valid_o` are low.
- R2: The port acts only when `cs_n_i` is low and `cs_i` is high. A write or a read under any other select combination has no effect: no serial output and no bus drive.
- R3: A write strobe falling while the port is selected and idle makes `ser_valid_o` rise exactly 3 clock edges after the strobe goes low, and not earlier.
- R4: A captured byte appears on `ser_data_o` most significant bit first, one bit per cycle, with `ser_valid_o` high for exactly 8 consecutive cycles.
- R5: A write strobe falling while a byte is still shifting is ignored. The byte in flight completes unchanged, and no further bits follow it.
- R6: A selected read drives `bus_oe_o` high 3 clock edges after the read strobe goes low. Bit 7 of `bus_o` is 1 when no byte is shifting (ready) and 0 while shifting (busy).
- R7: Whenever `bus_oe_o` is high, bits 6 to 0 of `bus_o` are all 1.
- R8: When both strobes are low together, the write takes effect (a byte is captured) and `bus_oe_o` stays low.
- R9: `bus_oe_o` is low whenever the port is not selected or no read strobe is active. It drops within 3 edges of the read strobe rising.
- R10: A write strobe held low loads exactly one byte. Capture happens on the strobe's asserting edge, not its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| bus_i | input | DW | Data bus input value |
| bus_o | output | DW | Data bus drive value (status byte) |
| bus_oe_o | output | 1 | Data bus output enable |
| ser_data_o | output | 1 | Serial configuration bit |
| ser_valid_o | output | 1 | Serial bit valid / busy indicator |

## Verification
A corrupted shift counter shows at once as a valid run other than 8 cycles, visible at the serial port when `ser_valid_o` falls. A bad shift register shows on the first wrong bit compared with the byte's expected MSB-first order. A wrong busy state shows in the next status read, three edges after the read strobe falls, as a ready bit of the wrong sense. A broken edge detector or select decode shows as extra or missing serial runs, counted per write attempt.

// File: rtl/alb_pkg.sv
`timescale 1ns/1ps
package alb_pkg;
  // synchroniser depth for the asynchronous bus controls
  localparam int SYNC_STAGES = 2;
  // bit positions inside the synchronised control vector
  localparam int CTL_SELN = 3;
  localparam int CTL_SEL  = 2;
  localparam int CTL_WR   = 1;
  localparam int CTL_RD   = 0;
  localparam int CTL_W    = 4;

  typedef enum logic {
    SH_IDLE  = 1'b0,
    SH_SHIFT = 1'b1
  } sh_state_e;
endpackage

// File: rtl/alb_sync.sv
`timescale 1ns/1ps
module alb_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RST_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/alb_shifter.sv
`timescale 1ns/1ps
module alb_shifter
  import alb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          bit_o
);
  localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  sh_state_e        state;
  logic [DW-1:0]    shreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SH_IDLE;
      shreg <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        SH_IDLE: begin
          // loads only when idle: a write during shifting is dropped
          if (load_i) begin
            shreg <= data_i;
            cnt   <= '0;
            state <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          shreg <= shreg << 1;
          if (cnt == LAST) begin
            state <= SH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign busy_o = (state == SH_SHIFT);
  assign bit_o  = shreg[DW-1];
endmodule

// File: rtl/alb_status.sv
`timescale 1ns/1ps
module alb_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act_i,
  input  logic          busy_i,
  output logic          oe_o,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o <= 1'b0;
      q_o  <= '1;
    end else begin
      oe_o <= rd_act_i;
      q_o  <= {~busy_i, {(DW-1){1'b1}}};
    end
  end
endmodule

// File: rtl/async_byte_loader.sv
`timescale 1ns/1ps
module async_byte_loader
  import alb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_i,
  input  logic          cs_i,
  input  logic          wr_n_i,
  input  logic          rd_n_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          ser_data_o,
  output logic          ser_valid_o
);
  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_s;
  logic             sel;
  logic             wr_act;
  logic             rd_act;
  logic             wr_prev;
  logic             load;
  logic             busy;

  // all controls converted to active-high before synchronising
  always_comb begin
    ctl_raw           = '0;
    ctl_raw[CTL_SELN] = ~cs_n_i;
    ctl_raw[CTL_SEL]  = cs_i;
    ctl_raw[CTL_WR]   = ~wr_n_i;
    ctl_raw[CTL_RD]   = ~rd_n_i;
  end

  alb_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ctl_raw),
    .q_o (ctl_s)
  );

  assign sel    = ctl_s[CTL_SELN] & ctl_s[CTL_SEL];
  assign wr_act = sel & ctl_s[CTL_WR];
  // write has priority: a concurrent write suppresses the status drive
  assign rd_act = sel & ctl_s[CTL_RD] & ~ctl_s[CTL_WR];

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b0;
    else     wr_prev <= wr_act;
  end

  assign load = wr_act & ~wr_prev;

  alb_shifter #(.DW(DW)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .data_i (bus_i),
    .busy_o (busy),
    .bit_o  (ser_data_o)
  );

  alb_status #(.DW(DW)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .rd_act_i (rd_act),
    .busy_i   (busy),
    .oe_o     (bus_oe_o),
    .q_o      (bus_o)
  );

  assign ser_valid_o = busy;
endmodule

// File: rtl/alb_checker.sv
`timescale 1ns/1ps
module alb_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n_i,
  input logic          cs_i,
  input logic          wr_n_i,
  input logic          rd_n_i,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic          ser_valid_o
);
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (rst)              run <= '0;
    else if (ser_valid_o) run <= run + 1'b1;
    else                  run <= '0;
  end

  assert_run_short_R4: assert property (@(posedge clk) disable iff (rst)
    ser_valid_o |-> (run < 16'(DW)));

  assert_run_full_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_valid_o) |-> (run == 16'(DW)));

  assert_low_ones_R7: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> (bus_o[DW-2:0] == {(DW-1){1'b1}}));

  assert_start_sel_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_valid_o) |-> $past(!cs_n_i && cs_i && !wr_n_i, 3));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_n_i, 3) |-> !bus_oe_o);

  assert_no_read_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_n_i, 3) |-> !bus_oe_o);

  assert_status_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_oe_o && $past(bus_oe_o)) |-> (bus_o[DW-1] == !$past(ser_valid_o)));
endmodule

bind async_byte_loader alb_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n_i      (cs_n_i),
  .cs_i        (cs_i),
  .wr_n_i      (wr_n_i),
  .rd_n_i      (rd_n_i),
  .bus_o       (bus_o),
  .bus_oe_o    (bus_oe_o),
  .ser_valid_o (ser_valid_o)
);

// File: tb/test_async_byte_loader.sv
`timescale 1ns/1ps
module test_async_byte_loader;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n_i = 1'b0;
  logic          cs_i = 1'b1;
  logic          wr_n_i = 1'b1;
  logic          rd_n_i = 1'b1;
  logic [DW-1:0] bus_i = '0;
  logic [DW-1:0] bus_o;
  logic          bus_oe_o;
  logic          ser_data_o;
  logic          ser_valid_o;

  int  total = 0;
  int  bad = 0;
  int  valid_cycles = 0;
  int  run = 0;
  bit  done = 1'b0;
  logic sb_q [$];

  always #2 clk = ~clk;

  async_byte_loader #(.DW(DW)) i_async_byte_loader (
    .clk(clk), .rst(rst), .cs_n_i(cs_n_i), .cs_i(cs_i),
    .wr_n_i(wr_n_i), .rd_n_i(rd_n_i), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .ser_data_o(ser_data_o), .ser_valid_o(ser_valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_byte(input logic [DW-1:0] b);
    for (int i = DW-1; i >= 0; i--) sb_q.push_back(b[i]);
  endtask

  // scoreboard monitor: pops one expected bit per valid cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (ser_valid_o) begin
        valid_cycles++;
        run++;
        if (sb_q.size() == 0) chk("R5 unexpected serial bit", 1, 0);
        else chk("R4 serial bit order", int'(ser_data_o), int'(sb_q.pop_front()));
      end else if (run != 0) begin
        chk("R4 valid run length", run, DW);
        run = 0;
      end
    end
  end

  task automatic write_byte(input logic [DW-1:0] b, input bit expect_load);
    if (expect_load) push_byte(b);
    bus_i  = b;
    wr_n_i = 1'b0;
    wait_n(2);
    chk("R3 valid not early", int'(ser_valid_o), 0);
    wait_n(1);
    chk("R3/R2 valid after three edges", int'(ser_valid_o), int'(expect_load));
    wait_n(1);
    wr_n_i = 1'b1;
    wait_n(10);
  endtask

  initial begin
    int base;
    wait_n(4);
    chk("R1 oe during reset", int'(bus_oe_o), 0);
    chk("R1 valid during reset", int'(ser_valid_o), 0);
    rst = 1'b0;
    wait_n(1);
    chk("R1 oe after reset", int'(bus_oe_o), 0);
    chk("R1 valid after reset", int'(ser_valid_o), 0);

    // R3 R4: several patterns
    write_byte(8'hA5, 1'b1);
    write_byte(8'h3C, 1'b1);
    write_byte(8'h81, 1'b1);

    // R2: wrong selects
    base = valid_cycles;
    cs_n_i = 1'b1;
    write_byte(8'h77, 1'b0);
    cs_n_i = 1'b0; cs_i = 1'b0;
    write_byte(8'h66, 1'b0);
    cs_i = 1'b1;
    chk("R2 no serial when deselected", valid_cycles - base, 0);

    // R6 R7: idle status read
    rd_n_i = 1'b0;
    wait_n(2);
    chk("R6 oe not early", int'(bus_oe_o), 0);
    wait_n(1);
    chk("R6 oe on read", int'(bus_oe_o), 1);
    chk("R6 R7 ready status byte", int'(bus_o), 8'hFF);
    rd_n_i = 1'b1;
    wait_n(3);
    chk("R9 oe released", int'(bus_oe_o), 0);

    // R6: status read while busy
    push_byte(8'h00);
    bus_i = 8'h00; wr_n_i = 1'b0;
    wait_n(3);
    wr_n_i = 1'b1; rd_n_i = 1'b0;
    wait_n(3);
    chk("R6 oe busy read", int'(bus_oe_o), 1);
    chk("R6 R7 busy status byte", int'(bus_o), 8'h7F);
    wait_n(1);
    rd_n_i = 1'b1;
    wait_n(10);
    chk("R9 oe after busy read", int'(bus_oe_o), 0);

    // R5: write during shifting ignored
    base = valid_cycles;
    push_byte(8'hF0);
    bus_i = 8'hF0; wr_n_i = 1'b0;
    wait_n(4);
    wr_n_i = 1'b1;
    wait_n(1);
    bus_i = 8'h0F; wr_n_i = 1'b0;
    wait_n(4);
    wr_n_i = 1'b1;
    wait_n(14);
    chk("R5 single byte shifted", valid_cycles - base, DW);

    // R8: both strobes low
    base = valid_cycles;
    push_byte(8'h5A);
    bus_i = 8'h5A; wr_n_i = 1'b0; rd_n_i = 1'b0;
    wait_n(3);
    chk("R8 no drive", int'(bus_oe_o), 0);
    chk("R8 write captured", int'(ser_valid_o), 1);
    wait_n(2);
    chk("R8 still no drive", int'(bus_oe_o), 0);
    wr_n_i = 1'b1; rd_n_i = 1'b1;
    wait_n(12);
    chk("R8 byte shifted", valid_cycles - base, DW);

    // R10: held strobe loads one byte
    base = valid_cycles;
    push_byte(8'h96);
    bus_i = 8'h96; wr_n_i = 1'b0;
    wait_n(20);
    wr_n_i = 1'b1;
    wait_n(4);
    chk("R10 one byte for held strobe", valid_cycles - base, DW);

    // R9: read while not selected
    cs_n_i = 1'b1; rd_n_i = 1'b0;
    wait_n(4);
    chk("R9 no drive deselected", int'(bus_oe_o), 0);
    rd_n_i = 1'b1; cs_n_i = 1'b0;
    wait_n(5);

    chk("R4 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule